// File: doc/BRIEF.md
# Translation Fault Classifier and Exception Vector Selector

This block sits next to a software-refilled TLB. Each time the TLB reports a translation fault, the block looks at three things: the faulting virtual address, the kind of fault, and the access attributes. From these it chooses the handler entry address the processor jumps to. It also latches a class code that the handler software can read. A cheap, frequent case is a missing entry for a user page. That case goes to a short dedicated entry. Rarer or costlier cases share one general entry.

Two programmable address windows describe where the page tables live:

- The page-table window holds the user page tables. A miss in this window is a missing second-level entry.
- The root window holds the pages that map the page tables themselves. A miss in this window is a third-level miss.

Any other kernel-half address counts as mapped kernel data. Software can set a fast-mode input. In fast mode, kernel-data misses get their own quick entry and second-level misses get theirs. Third-level misses, invalid pages and write-protect faults always take the general entry.

Results are registered. The vector, class code and a one-cycle valid pulse appear on the cycle after the fault is presented. The vector and class code then hold until the next fault that qualifies.

Top module: `tlbv_fault_vector`

## Requirements
- R1: While reset is asserted and after it is released, vec_valid is 0, class_code is 0 and vec_addr is 0 until the first qualifying fault.
- R2: A fault with fault_kind 0 (miss) at an address whose top bit is 0 (user half) produces class_code 0 and vec_addr = vec_base + 0x000. The result appears one cycle after fault_valid, with vec_valid high for exactly that one cycle. Faults on back-to-back cycles each produce their own result in turn.
- R3: A fault with fault_kind 1 (invalid entry) produces class_code 4 and vec_addr = vec_base + 0x180, whatever the address.
- R4: fault_kind 2 (entry present but not writable) produces class_code 5 and vec_addr = vec_base + 0x180 when is_store is 1. When is_store is 0, the fault is ignored: vec_valid stays 0 and class_code and vec_addr keep their values. fault_kind 3 (reserved) is ignored in the same way.
- R5: A miss at a kernel-half address that is in neither window produces class_code 1. Its vector is vec_base + 0x180 when fast_mode is 0, and vec_base + 0x080 when fast_mode is 1.
- R6: A miss at an address with (addr & ptw_mask) == ptw_base, and not in the root window, produces class_code 2. Its vector is vec_base + 0x180 when fast_mode is 0, and vec_base + 0x100 when fast_mode is 1.
- R7: A miss at an address with (addr & root_mask) == root_base produces class_code 3 and vec_addr = vec_base + 0x180 in both modes. The root window takes priority when both windows match.
- R8: A fault taken with user_mode 1 at a kernel-half address always gets vec_base + 0x180, even when fast_mode is 1. Its class_code is still chosen by address and kind.
- R9: Without a qualifying fault, vec_valid is 0 and class_code and vec_addr stay unchanged.
- R10: vec_base, fast_mode and the window inputs are used as they stand in the cycle the fault is presented. A later change does not alter a result already produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | A translation fault is presented this cycle |
| fault_addr | input | 32 | Faulting virtual address |
| fault_kind | input | 2 | 0 miss, 1 invalid, 2 not writable, 3 reserved |
| is_store | input | 1 | Faulting access is a store |
| user_mode | input | 1 | Access was made in user mode |
| fast_mode | input | 1 | Enables the kernel-data and second-level fast entries |
| vec_base | input | 32 | Base address of the handler entries |
| ptw_base | input | 32 | Match value of the page-table window |
| ptw_mask | input | 32 | Match mask of the page-table window |
| root_base | input | 32 | Match value of the root window |
| root_mask | input | 32 | Match mask of the root window |
| vec_valid | output | 1 | One-cycle pulse: new vector and class code |
| vec_addr | output | 32 | Selected handler entry address |
| class_code | output | 3 | Latched fault class |

## Verification
Two decode functions can claim the same fault in one cycle. The first case is when the root window lies inside the page-table window. The bench provokes it with a miss inside both windows and judges it correct only if class 3 and the general entry come out. The second case is a user-mode fault on a kernel-data address while fast mode is on. Here the privilege rule and the fast kernel-data route both apply. The bench expects class 1 with the general entry. A third stimulus changes the vector base in the cycle right after a fault. The bench checks that the result already produced still uses the old base.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

  typedef enum logic [1:0] {
    FK_MISS  = 2'd0,
    FK_INVAL = 2'd1,
    FK_WPROT = 2'd2,
    FK_RSVD  = 2'd3
  } fault_kind_e;

  typedef enum logic [2:0] {
    FC_USER   = 3'd0,
    FC_KDATA  = 3'd1,
    FC_PTE    = 3'd2,
    FC_ROOT   = 3'd3,
    FC_INVAL  = 3'd4,
    FC_MODIFY = 3'd5
  } fault_class_e;

  // entry slot index, multiplied by the slot stride to form the offset
  typedef enum logic [1:0] {
    SLOT_USER  = 2'd0,
    SLOT_KDATA = 2'd1,
    SLOT_PTE   = 2'd2,
    SLOT_GEN   = 2'd3
  } vec_slot_e;

  typedef struct packed {
    logic user_space;
    logic pt_hit;
    logic root_hit;
  } region_t;

endpackage

// File: rtl/tlbv_region_dec.sv
module tlbv_region_dec
  import tlbv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptw_base,
  input  logic [ADDR_W-1:0] ptw_mask,
  input  logic [ADDR_W-1:0] root_base,
  input  logic [ADDR_W-1:0] root_mask,
  output region_t           region
);

  localparam int TOP = ADDR_W - 1;

  logic in_kernel;
  logic pt_match;
  logic root_match;

  always_comb begin
    in_kernel  = addr[TOP];
    pt_match   = ((addr & ptw_mask) == ptw_base);
    root_match = ((addr & root_mask) == root_base);

    region.user_space = ~in_kernel;
    // windows only describe kernel-half mappings
    region.root_hit   = in_kernel & root_match;
    region.pt_hit     = in_kernel & pt_match & ~root_match;
  end

  always_comb begin
    if (region.user_space)
      assert (!region.pt_hit && !region.root_hit)
        else $error("p_window_kernel_only_r6: window hit in user half");
  end

endmodule

// File: rtl/tlbv_class_sel.sv
module tlbv_class_sel
  import tlbv_pkg::*;
(
  input  region_t      region,
  input  fault_kind_e  kind,
  input  logic         is_store,
  output logic         accept,
  output fault_class_e cls
);

  always_comb begin
    accept = 1'b0;
    cls    = FC_USER;
    unique case (kind)
      FK_MISS: begin
        accept = 1'b1;
        if (region.user_space)    cls = FC_USER;
        else if (region.root_hit) cls = FC_ROOT;
        else if (region.pt_hit)   cls = FC_PTE;
        else                      cls = FC_KDATA;
      end
      FK_INVAL: begin
        accept = 1'b1;
        cls    = FC_INVAL;
      end
      FK_WPROT: begin
        // a load to a read-only page is not a fault
        accept = is_store;
        cls    = FC_MODIFY;
      end
      default: begin
        accept = 1'b0;
        cls    = FC_USER;
      end
    endcase
  end

endmodule

// File: rtl/tlbv_vec_map.sv
module tlbv_vec_map
  import tlbv_pkg::*;
#(
  parameter bit HAS_FAST = 1'b1
) (
  input  fault_class_e cls,
  input  logic         fast_mode,
  input  logic         user_mode,
  output vec_slot_e    slot
);

  generate
    if (HAS_FAST) begin : g_fast
      always_comb begin
        unique case (cls)
          FC_USER:  slot = SLOT_USER;
          FC_KDATA: slot = (fast_mode && !user_mode) ? SLOT_KDATA : SLOT_GEN;
          FC_PTE:   slot = (fast_mode && !user_mode) ? SLOT_PTE : SLOT_GEN;
          default:  slot = SLOT_GEN;
        endcase
      end
    end else begin : g_basic
      logic unused_mode;
      assign unused_mode = fast_mode ^ user_mode;
      assign slot = (cls == FC_USER) ? SLOT_USER : SLOT_GEN;
    end
  endgenerate

  always_comb begin
    if (cls == FC_ROOT || cls == FC_INVAL || cls == FC_MODIFY)
      assert (slot == SLOT_GEN)
        else $error("p_slow_classes_general_r7: costly class on fast slot");
  end

endmodule

// File: rtl/tlbv_fault_vector.sv
module tlbv_fault_vector
  import tlbv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SLOT_STEP = 128,
  parameter bit HAS_FAST  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [1:0]        fault_kind,
  input  logic              is_store,
  input  logic              user_mode,
  input  logic              fast_mode,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [ADDR_W-1:0] ptw_base,
  input  logic [ADDR_W-1:0] ptw_mask,
  input  logic [ADDR_W-1:0] root_base,
  input  logic [ADDR_W-1:0] root_mask,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [2:0]        class_code
);

  localparam logic [ADDR_W-1:0] GEN_OFF = ADDR_W'(3 * SLOT_STEP);

  region_t           region;
  logic              accept;
  fault_class_e      cls_d;
  vec_slot_e         slot;
  logic [ADDR_W-1:0] vec_d;
  logic              load_en;

  fault_class_e      cls_q;
  logic [ADDR_W-1:0] vec_q;
  logic              valid_q;

  tlbv_region_dec #(.ADDR_W(ADDR_W)) i_region (
    .addr      (fault_addr),
    .ptw_base  (ptw_base),
    .ptw_mask  (ptw_mask),
    .root_base (root_base),
    .root_mask (root_mask),
    .region    (region)
  );

  tlbv_class_sel i_class (
    .region   (region),
    .kind     (fault_kind_e'(fault_kind)),
    .is_store (is_store),
    .accept   (accept),
    .cls      (cls_d)
  );

  tlbv_vec_map #(.HAS_FAST(HAS_FAST)) i_map (
    .cls       (cls_d),
    .fast_mode (fast_mode),
    .user_mode (user_mode),
    .slot      (slot)
  );

  // next-state
  always_comb begin
    load_en = fault_valid & accept;
    vec_d   = vec_base + ADDR_W'(int'(slot) * SLOT_STEP);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= FC_USER;
      vec_q   <= '0;
    end else begin
      valid_q <= load_en;
      if (load_en) begin
        cls_q <= cls_d;
        vec_q <= vec_d;
      end
    end
  end

  assign vec_valid  = valid_q;
  assign vec_addr   = vec_q;
  assign class_code = cls_q;

  p_user_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_kind == 2'd0 && !fault_addr[ADDR_W-1])
      |=> (vec_valid && class_code == 3'd0 && vec_addr == $past(vec_base)))
    else $error("p_user_fast_r2");

  p_invalid_general_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_kind == 2'd1)
      |=> (class_code == 3'd4 && vec_addr == $past(vec_base) + GEN_OFF))
    else $error("p_invalid_general_r3");

  p_load_wprot_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_kind == 2'd2 && !is_store)
      |=> (!vec_valid && $stable(class_code) && $stable(vec_addr)))
    else $error("p_load_wprot_quiet_r4");

  p_root_general_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && class_code == 3'd3) |-> (vec_addr == $past(vec_base) + GEN_OFF))
    else $error("p_root_general_r7");

  p_umode_general_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && user_mode && fault_addr[ADDR_W-1] && fault_kind != 2'd3
     && !(fault_kind == 2'd2 && !is_store))
      |=> (vec_addr == $past(vec_base) + GEN_OFF))
    else $error("p_umode_general_r8");

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> (!vec_valid && $stable(class_code) && $stable(vec_addr)))
    else $error("p_hold_r9");

  p_class_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    class_code <= 3'd5)
    else $error("p_class_legal_r9");

endmodule

// File: tb/test_tlbv_fault_vector.sv
module test_tlbv_fault_vector;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [31:0] OFF_USER  = 32'h000;
  localparam logic [31:0] OFF_KDATA = 32'h080;
  localparam logic [31:0] OFF_PTE   = 32'h100;
  localparam logic [31:0] OFF_GEN   = 32'h180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_valid;
  logic [31:0] fault_addr;
  logic [1:0]  fault_kind;
  logic        is_store;
  logic        user_mode;
  logic        fast_mode;
  logic [31:0] vec_base;
  logic [31:0] ptw_base;
  logic [31:0] ptw_mask;
  logic [31:0] root_base;
  logic [31:0] root_mask;
  logic        vec_valid;
  logic [31:0] vec_addr;
  logic [2:0]  class_code;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbv_fault_vector i_tlbv_fault_vector (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_kind(fault_kind), .is_store(is_store), .user_mode(user_mode),
    .fast_mode(fast_mode), .vec_base(vec_base), .ptw_base(ptw_base),
    .ptw_mask(ptw_mask), .root_base(root_base), .root_mask(root_mask),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .class_code(class_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one fault for one cycle; on return the registered result is visible
  task automatic fire(input logic [31:0] a, input logic [1:0] k,
                      input logic st, input logic um);
    @(negedge clk);
    fault_valid = 1'b1;
    fault_addr  = a;
    fault_kind  = k;
    is_store    = st;
    user_mode   = um;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic [2:0] cls, input logic [31:0] off);
    chk({tag, " valid"}, {31'd0, vec_valid}, 32'd1);
    chk({tag, " class"}, {29'd0, class_code}, {29'd0, cls});
    chk({tag, " vector"}, vec_addr, vec_base + off);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    chk("R1 valid in reset", {31'd0, vec_valid}, 32'd0);
    chk("R1 class in reset", {29'd0, class_code}, 32'd0);
    chk("R1 vector in reset", vec_addr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, vec_valid}, 32'd0);
    chk("R1 vector after reset", vec_addr, 32'd0);
  endtask

  task automatic t_user_miss;
    fire(32'h0040_1000, 2'd0, 1'b0, 1'b1);
    expect_result("R2 user miss", 3'd0, OFF_USER);
    @(negedge clk);
    chk("R2 pulse width", {31'd0, vec_valid}, 32'd0);
    // back-to-back: invalid then user miss
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = 32'hC100_0000; fault_kind = 2'd1;
    is_store = 1'b0; user_mode = 1'b0;
    @(negedge clk);
    fault_addr = 32'h7FFF_F000; fault_kind = 2'd0;
    expect_result("R2 back-to-back first", 3'd4, OFF_GEN);
    @(negedge clk);
    fault_valid = 1'b0;
    expect_result("R2 back-to-back second", 3'd0, OFF_USER);
  endtask

  task automatic t_invalid;
    fire(32'h0000_2000, 2'd1, 1'b0, 1'b1);
    expect_result("R3 invalid user addr", 3'd4, OFF_GEN);
    fast_mode = 1'b1;
    fire(32'hC000_4000, 2'd1, 1'b1, 1'b0);
    expect_result("R3 invalid pt addr fast", 3'd4, OFF_GEN);
    fast_mode = 1'b0;
  endtask

  task automatic t_modify;
    fire(32'h1000_0000, 2'd2, 1'b1, 1'b1);
    expect_result("R4 store to read-only", 3'd5, OFF_GEN);
    fire(32'hC100_0000, 2'd1, 1'b0, 1'b0);
    fire(32'h1000_0000, 2'd2, 1'b0, 1'b1);
    chk("R4 load to read-only valid", {31'd0, vec_valid}, 32'd0);
    chk("R4 load to read-only class", {29'd0, class_code}, 32'd4);
    fire(32'h0000_0000, 2'd3, 1'b1, 1'b0);
    chk("R4 reserved kind valid", {31'd0, vec_valid}, 32'd0);
    chk("R4 reserved kind class", {29'd0, class_code}, 32'd4);
    chk("R4 reserved kind vector", vec_addr, vec_base + OFF_GEN);
  endtask

  task automatic t_kdata;
    fast_mode = 1'b0;
    fire(32'hC100_0040, 2'd0, 1'b0, 1'b0);
    expect_result("R5 kdata basic", 3'd1, OFF_GEN);
    fast_mode = 1'b1;
    fire(32'hC100_0040, 2'd0, 1'b1, 1'b0);
    expect_result("R5 kdata fast", 3'd1, OFF_KDATA);
    fast_mode = 1'b0;
  endtask

  task automatic t_pte;
    fire(32'hC000_4000, 2'd0, 1'b0, 1'b0);
    expect_result("R6 second-level basic", 3'd2, OFF_GEN);
    fast_mode = 1'b1;
    fire(32'hC03F_F000, 2'd0, 1'b0, 1'b0);
    expect_result("R6 second-level fast", 3'd2, OFF_PTE);
    fast_mode = 1'b0;
  endtask

  task automatic t_root;
    fast_mode = 1'b1;
    fire(32'hC030_0100, 2'd0, 1'b0, 1'b0);
    expect_result("R7 root inside pt window fast", 3'd3, OFF_GEN);
    fast_mode = 1'b0;
    fire(32'hC030_0FFC, 2'd0, 1'b0, 1'b0);
    expect_result("R7 root basic", 3'd3, OFF_GEN);
  endtask

  task automatic t_umode;
    fast_mode = 1'b1;
    fire(32'hC100_0000, 2'd0, 1'b0, 1'b1);
    expect_result("R8 user mode kdata", 3'd1, OFF_GEN);
    fire(32'hC000_8000, 2'd0, 1'b0, 1'b1);
    expect_result("R8 user mode pte", 3'd2, OFF_GEN);
    fast_mode = 1'b0;
  endtask

  task automatic t_hold;
    fire(32'h0012_3000, 2'd0, 1'b0, 1'b0);
    fault_addr = 32'hC030_0000; fault_kind = 2'd1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R9 hold valid", {31'd0, vec_valid}, 32'd0);
    chk("R9 hold class", {29'd0, class_code}, 32'd0);
    chk("R9 hold vector", vec_addr, vec_base + OFF_USER);
  endtask

  task automatic t_base;
    logic [31:0] old_base;
    vec_base = 32'hBFC0_0200;
    fast_mode = 1'b1;
    fire(32'hC100_0000, 2'd0, 1'b0, 1'b0);
    expect_result("R10 new base", 3'd1, OFF_KDATA);
    old_base = vec_base;
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = 32'h0000_4000; fault_kind = 2'd0;
    @(negedge clk);
    fault_valid = 1'b0;
    vec_base  = 32'h9000_0000;
    fast_mode = 1'b0;
    @(negedge clk);
    chk("R10 result keeps sampled base", vec_addr, old_base + OFF_USER);
    chk("R10 class unchanged", {29'd0, class_code}, 32'd0);
  endtask

  initial begin
    fault_valid = 1'b0; fault_addr = '0; fault_kind = 2'd0;
    is_store = 1'b0; user_mode = 1'b0; fast_mode = 1'b0;
    vec_base  = 32'h8000_0000;
    ptw_base  = 32'hC000_0000; ptw_mask  = 32'hFFC0_0000;
    root_base = 32'hC030_0000; root_mask = 32'hFFFF_F000;
    t_reset();
    t_user_miss();
    t_invalid();
    t_modify();
    t_kdata();
    t_pte();
    t_root();
    t_umode();
    t_hold();
    t_base();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule